// File: doc/BRIEF.md
# CAN Controller Interrupt Prioritizer

This block collects every interrupt source of a CAN controller that holds a bank of message objects and drives two level interrupt lines towards the system. Each line carries a 16-bit identifier that names the highest-priority source still pending on it, so an interrupt handler can read one field and know which source to service. Message objects can be sent to either line. The status-change group and the error group always go to line 0.

Status-change events (wake-up, receive OK, transmit OK, last-error-code update) arrive as one-cycle pulses and set sticky flags. A read strobe for the error/status register clears those flags. Error conditions (parity, bus-off, error warning) arrive as levels. While a status or error interrupt is pending and enabled, line 0 reports a reserved identifier that outranks every message object. When a source clears, the identifier moves on to the next pending source without any further action.

Top module: `can_irq_prio`

## Requirements
- R1: `irq0` is high exactly when `en_line0` is set and `id0` is nonzero, and `irq1` is high exactly when `en_line1` is set and `id1` is nonzero. A line whose enable is clear stays low whatever is pending.
- R2: A line's identifier reads 0 when no enabled source is pending on that line.
- R3: While the status-change group or the error group is pending and enabled, `id0` reads 0x8000, ahead of every message object. `id1` never reads 0x8000.
- R4: Object k (bit k-1 of `obj_pend`) is reported as identifier k. Among the pending objects on a line, the lowest k wins.
- R5: When an object's pending bit drops, the line's identifier moves to the next pending object in priority order, or to 0 if none is left.
- R6: `obj_line_sel` bit k-1 routes object k: 0 selects line 0, 1 selects line 1.
- R7: `stat_flags` bits are, from bit 0 up: wake-up, receive OK, transmit OK and last-error-code. A pulse on an event sets its flag. A status-change interrupt is pending when `en_stat` is set and any flag is set. Status-change interrupts go only to line 0.
- R8: An error interrupt is pending while `en_err` is set and any of `err_parity`, `err_busoff` or `err_ewarn` is high. Error interrupts go only to line 0.
- R9: A `stat_rd` pulse clears all four status flags. If an event arrives in the same cycle as the read, that event's flag stays set.
- R10: All outputs are registered. A change in object pending bits, routing bits, error levels or enables shows one clock later. A status event shows on `stat_flags` one clock later and on `id0` two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| obj_pend | input | NUM_OBJ | Per-object interrupt pending bits |
| obj_line_sel | input | NUM_OBJ | Per-object line routing (0 = line 0, 1 = line 1) |
| ev_wake | input | 1 | Wake-up event pulse |
| ev_rxok | input | 1 | Receive-OK event pulse |
| ev_txok | input | 1 | Transmit-OK event pulse |
| ev_lec | input | 1 | Last-error-code update pulse |
| err_parity | input | 1 | Parity error condition (level) |
| err_busoff | input | 1 | Bus-off condition (level) |
| err_ewarn | input | 1 | Error warning condition (level) |
| en_line0 | input | 1 | Enable for interrupt line 0 |
| en_line1 | input | 1 | Enable for interrupt line 1 |
| en_stat | input | 1 | Enable for status-change interrupts |
| en_err | input | 1 | Enable for error interrupts |
| stat_rd | input | 1 | Error/status register read strobe |
| irq0 | output | 1 | Interrupt line 0 (level) |
| irq1 | output | 1 | Interrupt line 1 (level) |
| id0 | output | ID_W | Source identifier for line 0 |
| id1 | output | ID_W | Source identifier for line 1 |
| stat_flags | output | 4 | Sticky status-change flags |

## Verification
An eight-object instance is swept over all 256 pending patterns under four routing patterns: all to line 0, all to line 1, alternating, and mixed groups. These sweeps separate a correct lowest-index search from one that picks the highest index, ignores routing, or is off by one in identifier numbering. Enable sweeps show that gating applies to the line output and not to the identifier. Status pulses, error levels and read strobes are applied with objects also pending, which shows that the reserved identifier takes precedence, stays off line 1, and depends on the group enables. A read that lands in the same cycle as an event shows that the event is kept.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int STAT_N = 4;
  typedef enum logic [1:0] {
    ST_WAKE = 2'd0,
    ST_RXOK = 2'd1,
    ST_TXOK = 2'd2,
    ST_LEC  = 2'd3
  } stat_bit_e;
  localparam logic [15:0] STATUS_SRC_ID = 16'h8000;
endpackage

// File: rtl/can_irq_stat.sv
module can_irq_stat
  import can_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_N-1:0] events,
  input  logic              rd_strobe,
  output logic [STAT_N-1:0] flags
);
  logic [STAT_N-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else begin
      for (int b = 0; b < STAT_N; b++) begin
        if (events[b])      flags_q[b] <= 1'b1;
        else if (rd_strobe) flags_q[b] <= 1'b0;
      end
    end
  end

  assign flags = flags_q;

  // R9: an event present in the read cycle survives the read
  assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
    $past(events[ST_RXOK]) |-> flags_q[ST_RXOK]);

  // R9: a read with no event leaves the flag clear
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_strobe) && !$past(events[ST_WAKE])) |-> !flags_q[ST_WAKE]);
endmodule

// File: rtl/can_irq_pick.sv
module can_irq_pick #(
  parameter int W     = 64,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R4: the chosen bit is set and no lower-index bit is set
  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (rst)
    found |-> (vec[idx] && ((vec & ((W'(1) << idx) - W'(1))) == '0)));

  // R2: nothing found only when the vector is empty
  assert_none_empty_R2: assert property (@(posedge clk) disable iff (rst)
    !found |-> (vec == '0));
endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ = 64,
  parameter int ID_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OBJ-1:0] obj_pend,
  input  logic [NUM_OBJ-1:0] obj_line_sel,
  input  logic               ev_wake,
  input  logic               ev_rxok,
  input  logic               ev_txok,
  input  logic               ev_lec,
  input  logic               err_parity,
  input  logic               err_busoff,
  input  logic               err_ewarn,
  input  logic               en_line0,
  input  logic               en_line1,
  input  logic               en_stat,
  input  logic               en_err,
  input  logic               stat_rd,
  output logic               irq0,
  output logic               irq1,
  output logic [ID_W-1:0]    id0,
  output logic [ID_W-1:0]    id1,
  output logic [STAT_N-1:0]  stat_flags
);
  localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1;
  localparam int N_LINE = 2;
  localparam logic [ID_W-1:0] GROUP_ID = ID_W'(STATUS_SRC_ID);

  logic [STAT_N-1:0] flags;
  logic [STAT_N-1:0] ev_vec;

  assign ev_vec[ST_WAKE] = ev_wake;
  assign ev_vec[ST_RXOK] = ev_rxok;
  assign ev_vec[ST_TXOK] = ev_txok;
  assign ev_vec[ST_LEC]  = ev_lec;

  can_irq_stat u_stat (
    .clk       (clk),
    .rst       (rst),
    .events    (ev_vec),
    .rd_strobe (stat_rd),
    .flags     (flags)
  );

  logic group_pend;
  assign group_pend = (en_stat && (|flags)) ||
                      (en_err && (err_parity || err_busoff || err_ewarn));

  logic [NUM_OBJ-1:0] line_vec [N_LINE];
  logic [N_LINE-1:0]  line_found;
  logic [IDX_W-1:0]   line_idx [N_LINE];
  logic [ID_W-1:0]    obj_id   [N_LINE];

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    for (genvar k = 0; k < NUM_OBJ; k++) begin : g_obj
      assign line_vec[l][k] = obj_pend[k] && (obj_line_sel[k] == l[0]);
    end
    can_irq_pick #(.W(NUM_OBJ), .IDX_W(IDX_W)) u_pick (
      .clk   (clk),
      .rst   (rst),
      .vec   (line_vec[l]),
      .found (line_found[l]),
      .idx   (line_idx[l])
    );
    assign obj_id[l] = line_found[l] ? (ID_W'(line_idx[l]) + ID_W'(1)) : '0;
  end

  logic [ID_W-1:0] id0_next, id1_next;
  assign id0_next = group_pend ? GROUP_ID : obj_id[0];
  assign id1_next = obj_id[1];

  logic [ID_W-1:0] id0_q, id1_q;
  logic            irq0_q, irq1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      id0_q  <= '0;
      id1_q  <= '0;
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      id0_q  <= id0_next;
      id1_q  <= id1_next;
      irq0_q <= en_line0 && (id0_next != '0);
      irq1_q <= en_line1 && (id1_next != '0);
    end
  end

  assign id0        = id0_q;
  assign id1        = id1_q;
  assign irq0       = irq0_q;
  assign irq1       = irq1_q;
  assign stat_flags = flags;

  // R1/R5: an asserted line always names a source
  assert_line_has_src_R1: assert property (@(posedge clk) disable iff (rst)
    (irq0_q |-> id0_q != '0) and (irq1_q |-> id1_q != '0));

  // R1: a disabled line is low on the next cycle
  assert_gate_off_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(en_line1) |-> !irq1_q);

  // R3: the reserved group identifier never appears on line 1
  assert_group_line0_R3: assert property (@(posedge clk) disable iff (rst)
    id1_q != GROUP_ID);

  // R8: an enabled error level forces the group identifier on line 0
  assert_err_group_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(en_err) && $past(err_busoff)) |-> (id0_q == GROUP_ID));
endmodule

// File: tb/sim_can_irq_prio.sv
`timescale 1ns/1ps
module sim_can_irq_prio;
  localparam int N = 8;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] obj_pend = '0, obj_line_sel = '0;
  logic ev_wake = 0, ev_rxok = 0, ev_txok = 0, ev_lec = 0;
  logic err_parity = 0, err_busoff = 0, err_ewarn = 0;
  logic en_line0 = 0, en_line1 = 0, en_stat = 0, en_err = 0, stat_rd = 0;
  logic irq0, irq1;
  logic [IW-1:0] id0, id1;
  logic [3:0] stat_flags;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_irq_prio #(.NUM_OBJ(N), .ID_W(IW)) u0 (
    .clk, .rst, .obj_pend, .obj_line_sel,
    .ev_wake, .ev_rxok, .ev_txok, .ev_lec,
    .err_parity, .err_busoff, .err_ewarn,
    .en_line0, .en_line1, .en_stat, .en_err, .stat_rd,
    .irq0, .irq1, .id0, .id1, .stat_flags
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] exp_obj(input logic [N-1:0] p, input logic [N-1:0] s, input bit line);
    for (int i = 0; i < N; i++)
      if (p[i] && (s[i] == line)) return IW'(i + 1);
    return '0;
  endfunction

  task automatic settle();
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic pulse_ev(input logic [3:0] m, input logic rd);
    @(negedge clk);
    {ev_lec, ev_txok, ev_rxok, ev_wake} = m; stat_rd = rd;
    @(negedge clk);
    {ev_lec, ev_txok, ev_rxok, ev_wake} = '0; stat_rd = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] sels [4];
    sels[0] = 8'h00; sels[1] = 8'hFF; sels[2] = 8'h55; sels[3] = 8'hC3;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset id0", id0, 0);
    chk("R2 reset id1", id1, 0);
    chk("R1 reset irq0", irq0, 0);
    chk("R7 reset flags", stat_flags, 0);
    @(negedge clk); rst = 0; en_line0 = 1; en_line1 = 1; en_stat = 1; en_err = 1;

    // R4 R6 R2 R1: full sweep
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 256; p++) begin
        @(negedge clk); obj_pend = N'(p); obj_line_sel = sels[s];
        settle();
        chk("R4 R6 id0 sweep", id0, exp_obj(N'(p), sels[s], 1'b0));
        chk("R4 R6 id1 sweep", id1, exp_obj(N'(p), sels[s], 1'b1));
        chk("R1 irq0 sweep", irq0, exp_obj(N'(p), sels[s], 1'b0) != 0);
        chk("R1 irq1 sweep", irq1, exp_obj(N'(p), sels[s], 1'b1) != 0);
      end
    end

    // R1: enable gating, identifier still visible
    for (int e = 0; e < 4; e++) begin
      @(negedge clk); obj_pend = 8'h24; obj_line_sel = 8'h20;
      en_line0 = e[0]; en_line1 = e[1];
      settle();
      chk("R1 gate irq0", irq0, e[0]);
      chk("R1 gate irq1", irq1, e[1]);
      chk("R1 id0 ungated", id0, 3);
      chk("R1 id1 ungated", id1, 6);
    end
    @(negedge clk); en_line0 = 1; en_line1 = 1;

    // R5: clear pending objects one by one
    @(negedge clk); obj_pend = 8'b1001_0110; obj_line_sel = 8'h00;
    settle(); chk("R5 first", id0, 2);
    @(negedge clk); obj_pend = 8'b1001_0100; settle(); chk("R5 next", id0, 3);
    @(negedge clk); obj_pend = 8'b1001_0000; settle(); chk("R5 next2", id0, 5);
    @(negedge clk); obj_pend = 8'b0000_0000; settle();
    chk("R5 empty id", id0, 0); chk("R5 empty irq", irq0, 0);

    // R7 R3 R10: status event outranks objects, only on line 0
    @(negedge clk); obj_pend = 8'h03; obj_line_sel = 8'h02;
    settle();
    @(negedge clk); ev_txok = 1;
    @(posedge clk); #1;
    chk("R10 flag one clock", stat_flags, 4'b0100);
    chk("R10 id not yet", id0, 1);
    @(negedge clk); ev_txok = 0;
    @(posedge clk); #1;
    chk("R3 group id0", id0, 16'h8000);
    chk("R3 line1 object", id1, 2);
    chk("R7 irq0", irq0, 1);

    // R9: read clears, id returns to object
    pulse_ev(4'b0000, 1'b1);
    chk("R9 read clears", stat_flags, 0);
    chk("R9 id0 back", id0, 1);

    // R9: event in same cycle as read wins
    pulse_ev(4'b1001, 1'b0);
    chk("R7 flags set", stat_flags, 4'b1001);
    pulse_ev(4'b0010, 1'b1);
    chk("R9 event wins", stat_flags, 4'b0010);
    chk("R9 group still", id0, 16'h8000);
    pulse_ev(4'b0000, 1'b1);

    // R7: status disabled, flag kept but no group interrupt
    @(negedge clk); en_stat = 0;
    pulse_ev(4'b0001, 1'b0);
    settle();
    chk("R7 flag w/o enable", stat_flags, 4'b0001);
    chk("R7 disabled id0", id0, 1);
    @(negedge clk); en_stat = 1; settle();
    chk("R7 reenabled id0", id0, 16'h8000);
    pulse_ev(4'b0000, 1'b1);

    // R8: error levels, each one, with and without enable
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); {err_ewarn, err_busoff, err_parity} = 3'(1 << k); en_err = 1;
      settle();
      chk("R8 err id0", id0, 16'h8000);
      chk("R8 err not line1", id1, 2);
      @(negedge clk); en_err = 0; settle();
      chk("R8 err disabled", id0, 1);
    end
    @(negedge clk); {err_ewarn, err_busoff, err_parity} = '0; en_err = 1;
    obj_pend = '0; settle();
    chk("R2 idle again id0", id0, 0);
    chk("R2 idle again id1", id1, 0);

    // R3: group pending with line 0 disabled
    @(negedge clk); en_line0 = 0; err_busoff = 1; settle();
    chk("R3 id0 disabled line", id0, 16'h8000);
    chk("R1 irq0 disabled line", irq0, 0);
    @(negedge clk); err_busoff = 0; en_line0 = 1; settle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule